// File: doc/BRIEF.md
# Single-Bit Instruction Executor

This block runs one instruction per clock for a tiny machine whose data are single bits. Each 5-bit instruction word carries a 2-bit opcode in its top bits and three operand bits below it. The machine keeps state in two places: a pair of 1-bit registers and a four-cell 1-bit data memory. The four operations are XOR and NOR between registers, a load from memory into a register, and a store from a register into memory.

A sequencer presents a word on `insn_i` and raises `insn_valid_i`. The instruction takes effect on the next rising clock edge. The block has no functional result port. Its effect is visible only through the read-only debug ports, which mirror the register and memory contents.

Top module: `bitexec_top`

## Requirements
- R1: Bit layout is insn_i[4:3] = opcode, insn_i[2] = B0, insn_i[1] = B1, insn_i[0] = B2. Opcode 00 writes reg[B1] XOR reg[B2] into reg[B0].
- R2: Opcode 01 writes NOT(reg[B1] OR reg[B2]) into reg[B0].
- R3: Opcode 10 copies the memory cell at address {B1,B2} into reg[B0].
- R4: Opcode 11 writes reg[B0] into the memory cell at address {B1,B2}. No register changes.
- R5: B1 is the high address bit and B2 is the low one. For example, operand bits 0,1,1 address cell 3 and bits 0,1,0 address cell 2.
- R6: Only a store changes memory, and it changes only the addressed cell.
- R7: XOR, NOR and load change only the register selected by B0. The other register keeps its value.
- R8: When insn_valid_i is 0 on a rising edge, neither registers nor memory change, whatever insn_i holds.
- R9: When rst_i is 1 on a rising edge, both registers and all four memory cells are cleared to 0.
- R10: An XOR or NOR whose destination is also a source reads the value held before the edge.
- R11: dbg_regs_o[i] shows register i and dbg_mem_o[a] shows memory cell a. An executed instruction's result appears there right after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | Execute insn_i on this edge |
| insn_i | input | 5 | Instruction word: opcode in bits 4:3, then B0, B1, B2 |
| dbg_regs_o | output | 2 | Register contents, bit i = register i |
| dbg_mem_o | output | 4 | Memory contents, bit a = cell a |

## Verification
A fixed opening sequence sets up distinct register values and fills memory cells through stores. This makes results differ between a correct unit and one with swapped source selects, swapped address bits or XOR/NOR confusion. Instructions whose destination is also a source tell read-before-write apart from write-first forwarding. The sequence then walks all 32 instruction words against a running model, so every opcode meets every operand combination on evolving state. Idle cycles carry store-like words to show that the valid strobe gates both write paths. A reset in the middle of a run shows that every bit is cleared.

// File: rtl/bitexec_pkg.sv
package bitexec_pkg;

    parameter int REG_SEL_W = 1;
    parameter int ADDR_W    = 2;
    parameter int OPC_W     = 2;
    localparam int NUM_REGS  = 1 << REG_SEL_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int INSN_W    = OPC_W + REG_SEL_W + ADDR_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_XOR   = 2'b00,
        OPC_NOR   = 2'b01,
        OPC_LOAD  = 2'b10,
        OPC_STORE = 2'b11
    } opcode_e;

    typedef struct packed {
        logic                 rf_we;
        logic [REG_SEL_W-1:0] rf_waddr;
        logic [REG_SEL_W-1:0] rf_raddr_a;
        logic [REG_SEL_W-1:0] rf_raddr_b;
        logic                 mem_oe;
        logic                 mem_we;
        logic [ADDR_W-1:0]    mem_addr;
        logic                 wb_from_mem;
        logic                 use_nor;
    } ctrl_t;

endpackage

// File: rtl/bx_decode.sv
module bx_decode
    import bitexec_pkg::*;
(
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    output ctrl_t             ctrl_o
);
    opcode_e              opc;
    logic [REG_SEL_W-1:0] f_b0;
    logic [REG_SEL_W-1:0] f_b1;
    logic [REG_SEL_W-1:0] f_b2;

    always_comb begin
        opc  = opcode_e'(insn_i[INSN_W-1 -: OPC_W]);
        f_b0 = insn_i[2*REG_SEL_W +: REG_SEL_W];
        f_b1 = insn_i[REG_SEL_W +: REG_SEL_W];
        f_b2 = insn_i[0 +: REG_SEL_W];

        ctrl_o             = '0;
        ctrl_o.rf_waddr    = f_b0;
        ctrl_o.rf_raddr_a  = (opc == OPC_STORE) ? f_b0 : f_b1;
        ctrl_o.rf_raddr_b  = f_b2;
        // B1 is the high address bit, B2 the low one (R5)
        ctrl_o.mem_addr    = insn_i[0 +: ADDR_W];
        ctrl_o.use_nor     = (opc == OPC_NOR);
        ctrl_o.wb_from_mem = (opc == OPC_LOAD);

        if (valid_i) begin
            unique case (opc)
                OPC_XOR, OPC_NOR: ctrl_o.rf_we = 1'b1;
                OPC_LOAD: begin
                    ctrl_o.rf_we  = 1'b1;
                    ctrl_o.mem_oe = 1'b1;
                end
                OPC_STORE: ctrl_o.mem_we = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        assert (!(ctrl_o.rf_we && ctrl_o.mem_we)); // R4
    end
endmodule

// File: rtl/bx_logic.sv
module bx_logic (
    input  logic a_i,
    input  logic b_i,
    input  logic use_nor_i,
    output logic y_o
);
    logic xor_r;
    logic nor_r;

    always_comb begin
        xor_r = a_i ^ b_i;
        nor_r = ~(a_i | b_i);
        y_o   = use_nor_i ? nor_r : xor_r;
    end
endmodule

// File: rtl/bx_regfile.sv
module bx_regfile #(
    parameter int SEL_W = 1,
    localparam int N    = 1 << SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] waddr_i,
    input  logic             wdata_i,
    input  logic [SEL_W-1:0] raddr_a_i,
    input  logic [SEL_W-1:0] raddr_b_i,
    output logic             rdata_a_o,
    output logic             rdata_b_o,
    output logic [N-1:0]     regs_o
);
    logic [N-1:0] regs_d;
    logic [N-1:0] regs_q;

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign regs_d[i] = (we_i && (waddr_i == SEL_W'(i))) ? wdata_i : regs_q[i];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) regs_q <= '0;
        else       regs_q <= regs_d;
    end

    always_comb begin
        rdata_a_o = regs_q[raddr_a_i];
        rdata_b_o = regs_q[raddr_b_i];
        regs_o    = regs_q;
    end

    AST_RF_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(regs_q)); // R8
    AST_RF_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> ($countones(regs_q ^ $past(regs_q)) <= 1)); // R7
    AST_RF_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (regs_q == '0)); // R9
endmodule

// File: rtl/bx_datamem.sv
module bx_datamem #(
    parameter int AW    = 2,
    localparam int DEPTH = 1 << AW
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           oe_i,
    input  logic           we_i,
    input  logic [AW-1:0]  addr_i,
    input  logic           wdata_i,
    output logic           rdata_o,
    output logic [DEPTH-1:0] cells_o
);
    logic [DEPTH-1:0] cells_d;
    logic [DEPTH-1:0] cells_q;

    for (genvar a = 0; a < DEPTH; a++) begin : g_cell
        assign cells_d[a] = (we_i && (addr_i == AW'(a))) ? wdata_i : cells_q[a];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cells_q <= '0;
        else       cells_q <= cells_d;
    end

    always_comb begin
        rdata_o = oe_i ? cells_q[addr_i] : 1'b0;
        cells_o = cells_q;
    end

    AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |=> $stable(cells_q)); // R6
    AST_MEM_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> ($countones(cells_q ^ $past(cells_q)) <= 1)); // R6
    AST_MEM_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (cells_q == '0)); // R9
endmodule

// File: rtl/bitexec_top.sv
module bitexec_top
    import bitexec_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [NUM_REGS-1:0]  dbg_regs_o,
    output logic [MEM_DEPTH-1:0] dbg_mem_o
);
    ctrl_t ctrl;
    logic  rd_a;
    logic  rd_b;
    logic  alu_y;
    logic  mem_rd;
    logic  wb_data;

    bx_decode u_dec (
        .valid_i (insn_valid_i),
        .insn_i  (insn_i),
        .ctrl_o  (ctrl)
    );

    bx_regfile #(.SEL_W(REG_SEL_W)) u_rf (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .we_i      (ctrl.rf_we),
        .waddr_i   (ctrl.rf_waddr),
        .wdata_i   (wb_data),
        .raddr_a_i (ctrl.rf_raddr_a),
        .raddr_b_i (ctrl.rf_raddr_b),
        .rdata_a_o (rd_a),
        .rdata_b_o (rd_b),
        .regs_o    (dbg_regs_o)
    );

    bx_logic u_alu (
        .a_i       (rd_a),
        .b_i       (rd_b),
        .use_nor_i (ctrl.use_nor),
        .y_o       (alu_y)
    );

    bx_datamem #(.AW(ADDR_W)) u_mem (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .oe_i    (ctrl.mem_oe),
        .we_i    (ctrl.mem_we),
        .addr_i  (ctrl.mem_addr),
        .wdata_i (rd_a),
        .rdata_o (mem_rd),
        .cells_o (dbg_mem_o)
    );

    always_comb begin
        wb_data = ctrl.wb_from_mem ? mem_rd : alu_y;
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        !insn_valid_i |-> (!ctrl.rf_we && !ctrl.mem_we)); // R8
    AST_OE_ONLY_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl.mem_oe |-> (ctrl.rf_we && ctrl.wb_from_mem)); // R3
    AST_STORE_KEEPS_REGS: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl.mem_we |=> $stable(dbg_regs_o)); // R4
    AST_LOGIC_KEEPS_MEM: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl.rf_we && !ctrl.wb_from_mem) |=> $stable(dbg_mem_o)); // R6
endmodule

// File: tb/bitexec_top_test.sv
module bitexec_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vld = 1'b0;
    logic [4:0] insn = '0;
    logic [1:0] dbg_regs;
    logic [3:0] dbg_mem;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [1:0] m_reg = '0;
    logic [3:0] m_mem = '0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    bitexec_top uut (
        .clk_i        (clk),
        .rst_i        (rst),
        .insn_valid_i (vld),
        .insn_i       (insn),
        .dbg_regs_o   (dbg_regs),
        .dbg_mem_o    (dbg_mem)
    );

    // Monitor: compares state shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [5:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({dbg_regs, dbg_mem} !== e) begin
                    n_fail++;
                    $display("FAIL %s: regs=%b mem=%b expected regs=%b mem=%b",
                             t, dbg_regs, dbg_mem, e[5:4], e[3:0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Driver: applies one word and pushes the expected state
    task automatic apply(input logic [4:0] w, input logic v, input string t);
        @(negedge clk);
        rst  = 1'b0;
        insn = w;
        vld  = v;
        if (v) begin
            case (w[4:3])
                2'b00: m_reg[w[2]] = m_reg[w[1]] ^ m_reg[w[0]];
                2'b01: m_reg[w[2]] = ~(m_reg[w[1]] | m_reg[w[0]]);
                2'b10: m_reg[w[2]] = m_mem[w[1:0]];
                default: m_mem[w[1:0]] = m_reg[w[2]];
            endcase
        end
        exp_q.push_back({m_reg, m_mem});
        tag_q.push_back(t);
    endtask

    task automatic reset_cycle(input string t);
        @(negedge clk);
        rst   = 1'b1;
        vld   = 1'b0;
        m_reg = '0;
        m_mem = '0;
        exp_q.push_back(6'b0);
        tag_q.push_back(t);
    endtask

    initial begin
        reset_cycle("R9 initial");
        apply(5'b01_000, 1'b1, "R2 R10 nor r0,r0,r0");
        apply(5'b00_101, 1'b1, "R1 R11 xor r1,r0,r1");
        apply(5'b11_010, 1'b1, "R4 R5 store r0 @2");
        apply(5'b11_101, 1'b1, "R4 R5 store r1 @1");
        apply(5'b00_000, 1'b1, "R10 xor r0,r0,r0");
        apply(5'b10_001, 1'b1, "R3 R7 load r0 @1");
        apply(5'b10_100, 1'b1, "R3 R7 load r1 @0");
        apply(5'b11_011, 1'b0, "R8 idle store word");
        apply(5'b01_101, 1'b1, "R2 nor r1,r0,r1");
        apply(5'b01_111, 1'b1, "R10 nor r1,r1,r1");
        apply(5'b11_111, 1'b1, "R4 R5 store r1 @3");
        for (int k = 0; k < 32; k++) begin
            case (k[4:3])
                2'b00: apply(5'(k), 1'b1, "R1 R7 sweep");
                2'b01: apply(5'(k), 1'b1, "R2 R7 sweep");
                2'b10: apply(5'(k), 1'b1, "R3 R6 sweep");
                default: apply(5'(k), 1'b1, "R4 R6 sweep");
            endcase
        end
        apply(5'b10_011, 1'b0, "R8 idle load word");
        reset_cycle("R9 mid-run");
        apply(5'b01_000, 1'b1, "R2 after reset");
        apply(5'b11_001, 1'b1, "R4 R5 store r0 @1");
        apply(5'b00_100, 1'b0, "R8 idle xor word");
        @(negedge clk);
        vld = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule